// File: doc/BRIEF.md
# Flash Command Launch Controller

This block is the register-mapped front end of an embedded flash array. Software first programs a clock-divider register, then selects a parameter slot through a three-bit index register and writes the command words into the selected slot. Slot 0 carries the opcode in its upper byte. Software launches the command by writing one to the command-complete bit of the status register.

At launch the controller checks the command. A launch that fails a check sets an access-error or protection-violation flag, and the controller stays idle. A launch that passes starts the only array operation in scope, which is an erase-verify of the whole array. The verify walks the array one word per cycle and accumulates two status bits. Command-complete returns high when the walk ends.

A read of the array through the data port while a command is running returns zeros. The first such read also records its address in a fault register, with zeroed data and parity fields, and sets two fault flags. Real flash timing, program and erase pulses, and ECC computation are not modelled.

Top module: `fcmd_ctrl`

## Requirements
- R1: After reset, status (register address 1) reads 0x0080: command-complete (bit 7) is one and every other flag is zero. The divider (address 0) and the fault flags (address 7) read zero.
- R2: Any launch before the divider register has been written sets access-error (status bit 5). Command-complete stays one and nothing runs.
- R3: A launch whose opcode (upper byte of parameter slot 0) is not 0x01 sets access-error and runs nothing.
- R4: A launch of opcode 0x01 sets access-error and runs nothing in either of two cases: the index register (address 2) is not 0 at launch, or the load-sequence-active input is high.
- R5: A launch attempted while access-error or protection-violation (status bit 4) is set is ignored. Writing one to bit 5 or bit 4 of the status register clears that flag. The flags seen at the time of the launch decide whether it is blocked, even when the same write clears them.
- R6: A launch while the write-protect input is high sets protection-violation and runs nothing.
- R7: An accepted launch drops command-complete for exactly DEPTH cycles, one per array word, and then raises it again.
- R8: Erase-verify clears both status bits at launch. It then sets status bit 1 if any word is not all ones, and status bit 0 if any word has two or more zero bits. A fully erased array leaves both bits zero.
- R9: The array data port returns the stored word when idle and all zeros while a command runs.
- R10: A data-port read while a command runs, with both fault flags (address 7, bits 1 and 0) clear, sets both flags. It loads the fault address register (address 4) with the read address and zeroes the fault data (address 5) and fault parity (address 6) registers. Later reads do not overwrite the captured values while either flag is set.
- R11: Writing one to a bit of the fault-flag register clears that flag alone.
- R12: Writes to address 3 land in the parameter slot chosen by the index register, and reads of address 3 return that slot. The index (address 2) and the divider (address 0, bit 8 shows the divider was written) read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| wprot | input | 1 | Array write-protect state |
| load_seq_active | input | 1 | A data-field load sequence is still in progress |
| arr_wr_en | input | 1 | Array model word load strobe |
| arr_wr_addr | input | AW | Array model load address |
| arr_wr_data | input | DATA_W | Array model load data |
| arr_rd_en | input | 1 | Array data-port read strobe |
| arr_rd_addr | input | AW | Array data-port read address |
| arr_rd_data | output | DATA_W | Array data-port read data |

## Verification
On every cycle the assertions check four things: a rejected or blocked launch never takes the controller out of idle, the busy window lasts exactly DEPTH cycles, the data port gives zeros while busy, and a captured fault address is held until it is cleared. They also check that the verify status starts clear and never shows a non-correctable error without a read error. Only the bench scenarios can show that each rejection sets the right flag for the right cause. The same holds for the status bits after arrays with single-bit and multi-bit defects, the exact captured address, and parameter-slot steering by the index.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
   localparam int REG_W = 16;
   localparam logic [7:0] OPC_VERIFY_ALL = 8'h01;
   // register addresses
   localparam logic [2:0] RA_DIV   = 3'd0;
   localparam logic [2:0] RA_STAT  = 3'd1;
   localparam logic [2:0] RA_IDX   = 3'd2;
   localparam logic [2:0] RA_PARAM = 3'd3;
   localparam logic [2:0] RA_FADDR = 3'd4;
   localparam logic [2:0] RA_FDATA = 3'd5;
   localparam logic [2:0] RA_FPAR  = 3'd6;
   localparam logic [2:0] RA_FFLAG = 3'd7;
   // status bit positions
   localparam int SB_DONE = 7;
   localparam int SB_ACC  = 5;
   localparam int SB_PROT = 4;
   localparam int SB_ERR  = 1;
   localparam int SB_NC   = 0;
endpackage

// File: rtl/fcmd_array.sv
module fcmd_array #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 16,
   parameter int AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [AW-1:0]     scan_addr,
   output logic [DATA_W-1:0] scan_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;   // erased state
      end else if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   assign scan_data = mem[scan_addr];
   assign rd_data   = mem[rd_addr];
endmodule

// File: rtl/fcmd_scan.sv
module fcmd_scan #(
   parameter int DEPTH    = 16,
   parameter int DATA_W   = 16,
   parameter int NC_ZEROS = 2,
   parameter int AW       = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] word,
   output logic [AW-1:0]     addr,
   output logic              busy,
   output logic              st_err,
   output logic              st_nc
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
   localparam int ZW = $clog2(DATA_W + 1);

   logic [ZW-1:0] zeros;
   logic          bad_word, nc_word;

   generate
      if (NC_ZEROS < 1 || NC_ZEROS > DATA_W) begin : g_bad_nc
         $error("fcmd_scan: NC_ZEROS out of range");
      end
   endgenerate

   assign zeros    = ZW'($countones(~word));
   assign bad_word = (word != '1);
   assign nc_word  = (zeros >= ZW'(NC_ZEROS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         addr   <= '0;
         st_err <= 1'b0;
         st_nc  <= 1'b0;
      end else if (start) begin
         busy   <= 1'b1;
         addr   <= '0;
         st_err <= 1'b0;
         st_nc  <= 1'b0;
      end else if (busy) begin
         st_err <= st_err | bad_word;
         st_nc  <= st_nc | nc_word;
         addr   <= addr + 1'b1;
         if (addr == LAST) busy <= 1'b0;
      end
   end

   // R8: status starts clear after a launch; a non-correctable flag implies a read error
   p_status_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!st_err && !st_nc));
   p_nc_implies_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      st_nc |-> st_err);
endmodule

// File: rtl/fcmd_fault.sv
module fcmd_fault #(
   parameter int AW     = 4,
   parameter int DATA_W = 16,
   parameter int PAR_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              rd_en,
   input  logic [AW-1:0]     rd_addr,
   input  logic [1:0]        clr,
   output logic [1:0]        flags,
   output logic [AW-1:0]     f_addr,
   output logic [DATA_W-1:0] f_data,
   output logic [PAR_W-1:0]  f_par
);
   logic capture;
   assign capture = rd_en && busy && (flags == 2'b00);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags  <= 2'b00;
         f_addr <= '0;
         f_data <= '0;
         f_par  <= '0;
      end else if (capture) begin
         flags  <= 2'b11;
         f_addr <= rd_addr;
         f_data <= '0;
         f_par  <= '0;
      end else begin
         flags  <= flags & ~clr;
      end
   end

   // R10: a captured address is held while a flag stays set
   p_fault_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (flags != 2'b00 && clr == 2'b00) |=> $stable(f_addr));
endmodule

// File: rtl/fcmd_ctrl.sv
module fcmd_ctrl #(
   parameter int DEPTH    = 16,
   parameter int DATA_W   = 16,
   parameter int PAR_W    = 8,
   parameter int IDX_W    = 3,
   parameter int NC_ZEROS = 2,
   parameter int AW       = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [15:0]       reg_wdata,
   output logic [15:0]       reg_rdata,
   input  logic              wprot,
   input  logic              load_seq_active,
   input  logic              arr_wr_en,
   input  logic [AW-1:0]     arr_wr_addr,
   input  logic [DATA_W-1:0] arr_wr_data,
   input  logic              arr_rd_en,
   input  logic [AW-1:0]     arr_rd_addr,
   output logic [DATA_W-1:0] arr_rd_data
);
   import fcmd_pkg::*;

   localparam int NPARAM = 1 << IDX_W;
   localparam int CW     = $clog2(DEPTH + 1) + 1;

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("fcmd_ctrl: DEPTH must be a power of two of at least 2");
      end
      if (DATA_W > REG_W || PAR_W > REG_W || AW > REG_W) begin : g_bad_width
         $error("fcmd_ctrl: field wider than a register");
      end
      if (IDX_W < 1 || IDX_W > 4) begin : g_bad_idx
         $error("fcmd_ctrl: IDX_W out of range");
      end
   endgenerate

   logic [7:0]        div_q;
   logic              div_init;
   logic              acc_q, prot_q;
   logic [IDX_W-1:0]  idx_q;
   logic [REG_W-1:0]  param_q [NPARAM];

   logic              busy, done, st_err, st_nc;
   logic [AW-1:0]     scan_addr;
   logic [DATA_W-1:0] scan_word, mem_rd;
   logic [1:0]        fflags, fclr;
   logic [AW-1:0]     f_addr;
   logic [DATA_W-1:0] f_data;
   logic [PAR_W-1:0]  f_par;

   logic wr_stat, launch, set_acc, set_prot, start;
   logic [7:0] opc;

   assign done    = ~busy;
   assign opc     = param_q[0][15:8];
   assign wr_stat = reg_wr && (reg_addr == RA_STAT);
   assign launch  = wr_stat && reg_wdata[SB_DONE] && done && !acc_q && !prot_q;

   always_comb begin
      set_acc  = 1'b0;
      set_prot = 1'b0;
      start    = 1'b0;
      if (launch) begin
         if (wprot)                                  set_prot = 1'b1;
         else if (!div_init)                         set_acc  = 1'b1;
         else if (opc != OPC_VERIFY_ALL)             set_acc  = 1'b1;
         else if (idx_q != '0 || load_seq_active)    set_acc  = 1'b1;
         else                                        start    = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q    <= '0;
         div_init <= 1'b0;
         acc_q    <= 1'b0;
         prot_q   <= 1'b0;
         idx_q    <= '0;
         for (int i = 0; i < NPARAM; i++) param_q[i] <= '0;
      end else begin
         acc_q  <= (acc_q  & ~(wr_stat & reg_wdata[SB_ACC]))  | set_acc;
         prot_q <= (prot_q & ~(wr_stat & reg_wdata[SB_PROT])) | set_prot;
         if (reg_wr && reg_addr == RA_DIV) begin
            div_q    <= reg_wdata[7:0];
            div_init <= 1'b1;
         end
         if (reg_wr && reg_addr == RA_IDX)   idx_q <= reg_wdata[IDX_W-1:0];
         if (reg_wr && reg_addr == RA_PARAM) param_q[idx_q] <= reg_wdata;
      end
   end

   assign fclr = (reg_wr && reg_addr == RA_FFLAG) ? reg_wdata[1:0] : 2'b00;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_DIV:   reg_rdata = {7'd0, div_init, div_q};
         RA_STAT:  begin
            reg_rdata[SB_DONE] = done;
            reg_rdata[SB_ACC]  = acc_q;
            reg_rdata[SB_PROT] = prot_q;
            reg_rdata[SB_ERR]  = st_err;
            reg_rdata[SB_NC]   = st_nc;
         end
         RA_IDX:   reg_rdata = REG_W'(idx_q);
         RA_PARAM: reg_rdata = param_q[idx_q];
         RA_FADDR: reg_rdata = REG_W'(f_addr);
         RA_FDATA: reg_rdata = REG_W'(f_data);
         RA_FPAR:  reg_rdata = REG_W'(f_par);
         default:  reg_rdata = REG_W'(fflags);
      endcase
   end

   assign arr_rd_data = busy ? '0 : mem_rd;

   fcmd_array #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AW(AW)) u_array (
      .clk(clk), .rst_n(rst_n),
      .wr_en(arr_wr_en), .wr_addr(arr_wr_addr), .wr_data(arr_wr_data),
      .scan_addr(scan_addr), .scan_data(scan_word),
      .rd_addr(arr_rd_addr), .rd_data(mem_rd)
   );

   fcmd_scan #(.DEPTH(DEPTH), .DATA_W(DATA_W), .NC_ZEROS(NC_ZEROS), .AW(AW)) u_scan (
      .clk(clk), .rst_n(rst_n), .start(start), .word(scan_word),
      .addr(scan_addr), .busy(busy), .st_err(st_err), .st_nc(st_nc)
   );

   fcmd_fault #(.AW(AW), .DATA_W(DATA_W), .PAR_W(PAR_W)) u_fault (
      .clk(clk), .rst_n(rst_n), .busy(busy), .rd_en(arr_rd_en),
      .rd_addr(arr_rd_addr), .clr(fclr), .flags(fflags),
      .f_addr(f_addr), .f_data(f_data), .f_par(f_par)
   );

   // busy-window counter kept for the checks below
   logic [CW-1:0] busy_cyc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_cyc <= '0;
      else if (done) busy_cyc <= '0;
      else           busy_cyc <= busy_cyc + 1'b1;
   end

   // R2: a flag raised by a rejected launch leaves the controller idle
   p_reject_keeps_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(acc_q) |-> done);
   // R5: a launch attempted with a flag already set is ignored
   p_blocked_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && reg_wdata[SB_DONE] && done && (acc_q || prot_q)) |=> done);
   // R7: busy lasts exactly DEPTH cycles
   p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (busy_cyc == CW'(DEPTH)));
   p_busy_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (busy_cyc < CW'(DEPTH)));
   // R9: data port gives zeros while busy
   p_inv_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (arr_rd_data == '0));
endmodule

// File: tb/sim_fcmd_ctrl.sv
module sim_fcmd_ctrl;
   localparam int DEPTH = 16;
   localparam int DW    = 16;
   localparam int AW    = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_wr = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [15:0] reg_wdata = '0, reg_rdata;
   logic wprot = 1'b0, load_seq_active = 1'b0;
   logic arr_wr_en = 1'b0, arr_rd_en = 1'b0;
   logic [AW-1:0] arr_wr_addr = '0, arr_rd_addr = '0;
   logic [DW-1:0] arr_wr_data = '0, arr_rd_data;

   int n_chk = 0, n_fail = 0;

   always #2 clk = ~clk;   // 250 MHz

   fcmd_ctrl #(.DEPTH(DEPTH), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wprot(wprot),
      .load_seq_active(load_seq_active), .arr_wr_en(arr_wr_en),
      .arr_wr_addr(arr_wr_addr), .arr_wr_data(arr_wr_data),
      .arr_rd_en(arr_rd_en), .arr_rd_addr(arr_rd_addr), .arr_rd_data(arr_rd_data)
   );

   // entry: {req[3:0], is_read, addr[2:0], data/expected[15:0]}
   localparam int NV = 29;
   localparam logic [23:0] VEC [NV] = '{
      {4'd1,  1'b1, 3'd1, 16'h0080},  // R1 status after reset
      {4'd1,  1'b1, 3'd0, 16'h0000},  // R1 divider after reset
      {4'd1,  1'b1, 3'd7, 16'h0000},  // R1 fault flags after reset
      {4'd0,  1'b0, 3'd2, 16'h0000},
      {4'd0,  1'b0, 3'd3, 16'h0100},
      {4'd12, 1'b1, 3'd3, 16'h0100},  // R12 slot 0 readback
      {4'd0,  1'b0, 3'd1, 16'h0080},  // launch, divider unset
      {4'd2,  1'b1, 3'd1, 16'h00A0},  // R2 access error, still idle
      {4'd0,  1'b0, 3'd0, 16'h0005},
      {4'd0,  1'b0, 3'd1, 16'h0080},  // launch while flag set
      {4'd5,  1'b1, 3'd1, 16'h00A0},  // R5 ignored
      {4'd0,  1'b0, 3'd1, 16'h0020},
      {4'd5,  1'b1, 3'd1, 16'h0080},  // R5 w1c
      {4'd12, 1'b1, 3'd0, 16'h0105},  // R12 divider readback
      {4'd0,  1'b0, 3'd2, 16'h0001},
      {4'd0,  1'b0, 3'd3, 16'h1234},
      {4'd12, 1'b1, 3'd3, 16'h1234},  // R12 slot 1
      {4'd12, 1'b1, 3'd2, 16'h0001},  // R12 index readback
      {4'd0,  1'b0, 3'd1, 16'h0080},  // launch with index 1
      {4'd4,  1'b1, 3'd1, 16'h00A0},  // R4 index not zero
      {4'd0,  1'b0, 3'd1, 16'h0020},
      {4'd0,  1'b0, 3'd2, 16'h0000},
      {4'd12, 1'b1, 3'd3, 16'h0100},  // R12 back to slot 0
      {4'd0,  1'b0, 3'd3, 16'h0700},
      {4'd0,  1'b0, 3'd1, 16'h0080},  // unknown opcode
      {4'd3,  1'b1, 3'd1, 16'h00A0},  // R3
      {4'd0,  1'b0, 3'd1, 16'h0020},
      {4'd0,  1'b0, 3'd3, 16'h0100},
      {4'd3,  1'b1, 3'd1, 16'h0080}   // R3 nothing ran
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input string tag, input logic [2:0] a, input logic [15:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1 chk(tag, reg_rdata, exp);
   endtask

   task automatic awr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      arr_wr_en = 1'b1; arr_wr_addr = a; arr_wr_data = d;
      @(negedge clk);
      arr_wr_en = 1'b0;
   endtask

   // launch, then count cycles with command-complete low
   task automatic run_verify(output int n);
      wr(3'd1, 16'h0080);
      reg_addr = 3'd1;
      n = 0;
      #1;
      while (reg_rdata[7] == 1'b0 && n < 1000) begin
         n++;
         @(negedge clk);
         #1;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][19]) rd($sformatf("R%0d vec %0d", VEC[i][23:20], i),
                            VEC[i][18:16], VEC[i][15:0]);
         else wr(VEC[i][18:16], VEC[i][15:0]);
      end

      // R6 write protect
      wprot = 1'b1;
      wr(3'd1, 16'h0080);
      wprot = 1'b0;
      rd("R6 protection flag", 3'd1, 16'h0090);
      wr(3'd1, 16'h0010);
      rd("R6 protection cleared", 3'd1, 16'h0080);

      // R4 load sequence still active
      load_seq_active = 1'b1;
      wr(3'd1, 16'h0080);
      load_seq_active = 1'b0;
      rd("R4 load sequence active", 3'd1, 16'h00A0);
      wr(3'd1, 16'h0020);

      // R7 / R8 clean array
      run_verify(n);
      chk("R7 busy cycles", 16'(n), 16'(DEPTH));
      rd("R8 erased array status", 3'd1, 16'h0080);

      // R9 / R10 read collision
      wr(3'd1, 16'h0080);
      arr_rd_en = 1'b1; arr_rd_addr = 4'd5;
      #1 chk("R9 busy read zero", arr_rd_data, 16'h0000);
      @(negedge clk);
      arr_rd_addr = 4'd9;
      @(negedge clk);
      arr_rd_en = 1'b0;
      rd("R10 fault flags", 3'd7, 16'h0003);
      rd("R10 fault address kept first", 3'd4, 16'h0005);
      rd("R10 fault data", 3'd5, 16'h0000);
      rd("R10 fault parity", 3'd6, 16'h0000);
      repeat (DEPTH) @(negedge clk);
      rd("R7 complete after collision run", 3'd1, 16'h0080);
      wr(3'd7, 16'h0001);
      rd("R11 clear one fault flag", 3'd7, 16'h0002);
      wr(3'd7, 16'h0002);
      rd("R11 clear other fault flag", 3'd7, 16'h0000);

      // R9 idle read, R8 single-bit defect
      awr(4'd3, 16'hFFFE);
      @(negedge clk);
      arr_rd_addr = 4'd3;
      #1 chk("R9 idle read", arr_rd_data, 16'hFFFE);
      run_verify(n);
      rd("R8 one zero bit", 3'd1, 16'h0082);

      // R8 multi-bit defect
      awr(4'd15, 16'h00FF);
      run_verify(n);
      chk("R7 busy cycles again", 16'(n), 16'(DEPTH));
      rd("R8 non-correctable", 3'd1, 16'h0083);

      // R8 status cleared by next launch
      awr(4'd3, 16'hFFFF);
      awr(4'd15, 16'hFFFF);
      run_verify(n);
      rd("R8 status cleared", 3'd1, 16'h0080);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule